// File: doc/BRIEF.md
# Cycle-Counting Interrupt Timer

This block is a 16-bit down-counter that raises an interrupt request after a programmed number of processor clock cycles. Software programs it with command writes. Each write carries a 4-bit command code, an 8-bit data value and a one-cycle write strobe. Three codes reach the block: code 13 is the control word, and codes 14 and 15 load the counter one byte at a time. The block ignores every other code, so it can share a command bus with other register decoders.

Counting and interrupt generation have separate enables. While counting is enabled, the counter drops by one on every rising clock edge. When a decrement takes it from 0x0000 to 0xFFFF and interrupts are enabled, a pending flag is set. That flag drives the active-high, level-sensitive request output. Only a control write clears the flag. The counter never reloads itself; after a wrap it keeps counting down from 0xFFFF.

The reset input is asynchronous and active low. Its release passes through a two-stage synchronizer inside the block.

Top module: `cyc_irq_timer`

## Requirements
- R1: While reset is asserted, and after it is released, the counter is 0x0000, both enables are off and `irq_o` is low.
- R2: A write with code 13 loads the enables from the data byte: bit 7 turns counting on and bit 0 turns interrupt generation on. A later control write overrides both.
- R3: Any write with code 13 clears a pending interrupt, whatever data value it carries.
- R4: Code 14 replaces counter bits 7:0 and code 15 replaces bits 15:8. The other byte keeps its value.
- R5: While counting is enabled, the counter decrements by one each clock, wrapping modulo 65536. While counting is disabled, the counter holds its value.
- R6: A decrement from 0x0000 to 0xFFFF while interrupts are enabled sets the pending flag. `irq_o` then stays high until a control write.
- R7: The counter does not reload after a wrap. The next wrap comes 65536 counting cycles later.
- R8: When a counter-byte write and a decrement fall in the same cycle, the written value is stored and no decrement happens in that cycle.
- R9: With counting disabled, or with interrupts disabled, no interrupt is raised.
- R10: Writes with codes other than 13, 14 and 15 change neither the counter, the enables nor the pending flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock; one count per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Write strobe for one command, one cycle wide |
| cmd_code | input | 4 | Command code: 13 control, 14 low byte, 15 high byte |
| cmd_data | input | 8 | Data byte of the command |
| irq_o | output | 1 | Active-high level interrupt request |

## Verification
The bench measures the delay from the enabling control write to the rising edge of `irq_o`. For a loaded value N that delay is N+1 cycles. A design that fires on reaching zero instead of on the wrap arrives one cycle early. A design that also decrements during a byte write arrives one cycle early in the collision test.

A second wrap is timed across the full 65536-cycle period, so a design that reloads the programmed value fails that test. Other tests check that:
- the counter stays frozen while counting is off, so a design that counts in that state fires early;
- writing one byte leaves the other byte intact;
- the request stays high through writes with unrelated codes;
- a reset clears the counter, so a first wrap after reset arrives after exactly one cycle.

// File: rtl/cit_pkg.sv
package cit_pkg;
  // Command codes seen on the command bus
  localparam int unsigned CODE_CTRL  = 13;
  localparam int unsigned CODE_BYTE0 = 14;  // byte b of the counter uses CODE_BYTE0 + b

  // Bit positions inside the control data byte
  localparam int unsigned CTRL_IRQ_BIT = 0;
  localparam int unsigned CTRL_RUN_BIT = 7;

  typedef struct packed {
    logic run;     // counting enabled
    logic irq_en;  // interrupt generation enabled
  } cit_ctrl_t;
endpackage

// File: rtl/cit_rst_sync.sv
module cit_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cit_cmd_decode.sv
module cit_cmd_decode
  import cit_pkg::*;
#(
  parameter int unsigned CMD_W     = 4,
  parameter int unsigned NUM_BYTES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_we,
  input  logic [CMD_W-1:0]     cmd_code,
  input  logic                 run_bit,
  input  logic                 irq_bit,
  output logic                 ctrl_wr_o,
  output logic [NUM_BYTES-1:0] byte_wr_o,
  output cit_ctrl_t            ctrl_o
);
  localparam logic [CMD_W-1:0] CTRL_CODE = CMD_W'(CODE_CTRL);

  cit_ctrl_t ctrl_q, ctrl_d;

  assign ctrl_wr_o = cmd_we && (cmd_code == CTRL_CODE);

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte_dec
    localparam logic [CMD_W-1:0] BYTE_CODE = CMD_W'(CODE_BYTE0 + b);
    assign byte_wr_o[b] = cmd_we && (cmd_code == BYTE_CODE);
  end

  always_comb begin
    ctrl_d        = ctrl_q;
    ctrl_d.run    = run_bit;
    ctrl_d.irq_en = irq_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctrl_q <= '0;
    else if (ctrl_wr_o) ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  // R2: a control write loads both enables from the strobed data bits
  p_ctrl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_o |=> (ctrl_o.run == $past(run_bit)) && (ctrl_o.irq_en == $past(irq_bit)));

  // R10: without a control write the enables do not move
  p_ctrl_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr_o |=> $stable(ctrl_o));
endmodule

// File: rtl/cit_down_counter.sv
module cit_down_counter #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_BYTES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [NUM_BYTES-1:0] byte_wr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic                 wrap_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d, load_val;
  logic             any_wr, cnt_ce;

  assign any_wr = |byte_wr;
  assign cnt_ce = any_wr | run;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte_mux
    assign load_val[b*DATA_W +: DATA_W] = byte_wr[b] ? wr_data : cnt_q[b*DATA_W +: DATA_W];
  end

  // A byte write has priority over the decrement in the same cycle
  always_comb begin
    cnt_d  = cnt_q;
    wrap_o = 1'b0;
    if (any_wr) begin
      cnt_d = load_val;
    end else if (run) begin
      cnt_d  = cnt_q - ONE;
      wrap_o = (cnt_q == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  // R5: one step down per enabled cycle, modulo the counter width
  p_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !any_wr) |=> (cnt_q == $past(cnt_q) - ONE));

  // R5: counting off and no write means the value holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !any_wr) |=> $stable(cnt_q));

  // R6: a wrap leaves the counter at all ones
  p_wrap_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == '1));

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte_chk
    // R4 and R8: the written byte takes the data, even while counting
    p_byte_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      byte_wr[b] |=> (cnt_q[b*DATA_W +: DATA_W] == $past(wr_data)));
    // R4 and R8: the other bytes are untouched by that write
    p_byte_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (any_wr && !byte_wr[b]) |=> $stable(cnt_q[b*DATA_W +: DATA_W]));
  end
endmodule

// File: rtl/cit_irq_latch.sv
module cit_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic wrap,
  input  logic irq_en,
  output logic pend_o
);
  logic pend_q, pend_d, set_hit;

  assign set_hit = wrap & irq_en;

  always_comb begin
    pend_d = pend_q;
    if (ctrl_wr) pend_d = 1'b0;
    if (set_hit) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R6: a wrap with interrupts enabled makes the request pending
  p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && irq_en) |=> pend_o);

  // R6: the request stays high until a control write
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !ctrl_wr) |=> pend_o);

  // R3: a control write clears the request when no new wrap lands at the same time
  p_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !(wrap && irq_en)) |=> !pend_o);

  // R9: the request never rises without a wrap
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_o && !wrap) |=> !pend_o);
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
  import cit_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CMD_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              irq_o
);
  localparam int unsigned NUM_BYTES = CNT_W / DATA_W;

  logic                 rst_sync_n;
  logic                 ctrl_wr;
  logic [NUM_BYTES-1:0] byte_wr;
  cit_ctrl_t            ctrl;
  logic                 wrap;

  cit_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cit_cmd_decode #(.CMD_W(CMD_W), .NUM_BYTES(NUM_BYTES)) u_decode (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_we    (cmd_we),
    .cmd_code  (cmd_code),
    .run_bit   (cmd_data[CTRL_RUN_BIT]),
    .irq_bit   (cmd_data[CTRL_IRQ_BIT]),
    .ctrl_wr_o (ctrl_wr),
    .byte_wr_o (byte_wr),
    .ctrl_o    (ctrl)
  );

  cit_down_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W), .NUM_BYTES(NUM_BYTES)) u_counter (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (ctrl.run),
    .byte_wr (byte_wr),
    .wr_data (cmd_data),
    .wrap_o  (wrap)
  );

  cit_irq_latch u_irq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ctrl_wr (ctrl_wr),
    .wrap    (wrap),
    .irq_en  (ctrl.irq_en),
    .pend_o  (irq_o)
  );
endmodule

// File: tb/cyc_irq_timer_bench.sv
module cyc_irq_timer_bench;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic [3:0] cmd_code = '0;
  logic [7:0] cmd_data = '0;
  logic       irq;
  int         checks = 0;
  int         errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cyc_irq_timer u_cyc_irq_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_we   (cmd_we),
    .cmd_code (cmd_code),
    .cmd_data (cmd_data),
    .irq_o    (irq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s irq actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [3:0] code, input logic [7:0] data);
    cmd_we = 1'b1; cmd_code = code; cmd_data = data;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic load(input logic [15:0] v);
    wr(4'd14, v[7:0]);
    wr(4'd15, v[15:8]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R1 async", irq, 1'b0);
    repeat (3) @(negedge clk);
    check("R1 during", irq, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after", irq, 1'b0);
  endtask

  // Expect irq low for n-1 falling edges and high at the n-th
  task automatic expect_fire(input int n, input string req);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      check(req, irq, (i == n));
    end
  endtask

  task automatic expect_low(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, irq, 1'b0);
    end
  endtask

  task automatic t_basic_and_no_reload();
    do_reset();
    load(16'd5);
    wr(4'd13, 8'h81);
    expect_fire(6, "R6 wrap after N+1");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R6 level held", irq, 1'b1);
    end
    wr(4'd13, 8'h81);
    check("R3 ack", irq, 1'b0);
    expect_fire(65532, "R7 no reload");
  endtask

  task automatic t_irq_disabled();
    do_reset();
    load(16'd2);
    wr(4'd13, 8'h80);
    expect_low(10, "R9 irq off");
    do_reset();
    load(16'd10);
    wr(4'd13, 8'h80);
    expect_low(3, "R9 irq off");
    wr(4'd13, 8'h81);
    expect_fire(7, "R5 counted while irq off");
  endtask

  task automatic t_count_disabled();
    do_reset();
    load(16'd4);
    wr(4'd13, 8'h01);
    expect_low(20, "R9 count off");
    wr(4'd13, 8'h81);
    expect_fire(5, "R5 held while off");
  endtask

  task automatic t_bytes();
    do_reset();
    wr(4'd14, 8'h07);
    wr(4'd15, 8'h01);
    wr(4'd14, 8'h02);
    wr(4'd13, 8'h81);
    expect_fire(259, "R4 low byte keeps high");
    do_reset();
    wr(4'd14, 8'h03);
    wr(4'd15, 8'h02);
    wr(4'd15, 8'h00);
    wr(4'd13, 8'h81);
    expect_fire(4, "R4 high byte keeps low");
  endtask

  task automatic t_write_priority_and_ack();
    do_reset();
    load(16'h0050);
    wr(4'd13, 8'h81);
    repeat (2) @(negedge clk);
    wr(4'd14, 8'h04);
    expect_fire(5, "R8 write beats decrement");
    wr(4'd3, 8'hFF);
    check("R10 other code", irq, 1'b1);
    wr(4'd12, 8'h00);
    check("R10 other code", irq, 1'b1);
    wr(4'd13, 8'h00);
    check("R3 ack any data", irq, 1'b0);
    expect_low(50, "R2 both off");
  endtask

  task automatic t_reset_mid_run();
    do_reset();
    load(16'h0100);
    wr(4'd13, 8'h81);
    repeat (5) @(negedge clk);
    do_reset();
    expect_low(20, "R1 enables cleared");
    wr(4'd13, 8'h81);
    expect_fire(1, "R1 counter cleared");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    t_basic_and_no_reload();
    t_irq_disabled();
    t_count_disabled();
    t_bytes();
    t_write_priority_and_ack();
    t_reset_mid_run();
    summary();
  end
endmodule